// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block sits between a device's core logic and its pads. It gives every input pad one scan cell and every output pad two: one for the driven value and one for the output enable. All the cells form a single serial register. An external test controller runs the register through three strobes: capture, shift and update. Capture samples the levels at the pad boundary. Shift moves data one bit per rising test-clock edge from `scan_in` toward `scan_out`. Update copies the shifted data into latches on the falling edge.

When `ext_mode` is low, the core drives the pads directly and the chain does not disturb normal operation. When `ext_mode` is high, every output pad takes its value and its enable from the update latches. A pattern of enable bits set to zero isolates the device by releasing its outputs. The update latches hold the pads steady while the next pattern shifts through.

The scan path is bit-serial and has no valid/ready handshake. Each enabled rising edge consumes one `scan_in` bit and presents one new `scan_out` bit, so there is no back-pressure. The controller alone sets the pace by gating the strobes. The controller state machine and instruction decoding live outside this block.

Top module: `bscan_chain`

## Requirements
- R1: While `trst_n` is low, every chain cell and every update latch is cleared to 0. As a result `scan_out` is 0 and, with `ext_mode` high, every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: With `ext_mode` low, `pin_out` equals `core_out` and `pin_oe` equals `core_oe`, whatever shift or update activity takes place. `core_in` always equals `pin_in`.
- R3: The chain positions are fixed as follows. Position i (0 to N_IN-1) is input pad i. Position N_IN+2j holds the value of output pad j. Position N_IN+2j+1 holds the enable of output pad j. Position 0 is the one presented at `scan_out`.
- R4: On a rising `tck` edge with `cap_en` high, each input cell loads its `pin_in` bit. Each output value cell loads the `pin_out` bit currently presented, and each enable cell loads the `pin_oe` bit currently presented.
- R5: On a rising edge with `shift_en` high and `cap_en` low, each cell takes the content of the next higher position. The top position takes `scan_in`. After N_IN+2*N_OUT shifts the old contents have left least-significant position first, and the bits shifted in occupy the chain in the order they entered (first bit at position 0).
- R6: The update latches load the chain contents on a falling `tck` edge while `upd_en` is high, and hold their value at all other times. In particular, shifting does not change `pin_out` or `pin_oe` in external mode.
- R7: With `ext_mode` high, `pin_out[j]` equals the value latch of pad j and `pin_oe[j]` equals its enable latch. An enable latch of 1 drives the pad and 0 releases it.
- R8: In external mode, with all enable latches loaded with 0, every `pin_oe` bit is 0 regardless of `core_oe` and of the value latches.
- R9: When `cap_en` and `shift_en` are both high on an edge, capture takes effect and no shift happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| cap_en | input | 1 | Capture strobe, sampled on rising edge |
| shift_en | input | 1 | Shift strobe, sampled on rising edge |
| upd_en | input | 1 | Update strobe, acts on falling edge |
| ext_mode | input | 1 | 1 = pads driven from update latches |
| scan_in | input | 1 | Serial data into the highest position |
| scan_out | output | 1 | Serial data from position 0 |
| core_out | input | N_OUT | Core values for the output pads |
| core_oe | input | N_OUT | Core enables for the output pads |
| core_in | output | N_IN | Input pad levels passed to the core |
| pin_in | input | N_IN | Levels present on the input pads |
| pin_out | output | N_OUT | Values driven to the output pads |
| pin_oe | output | N_OUT | Output pad enables, 1 = drive |

## Verification
The bench builds the block with N_IN = 4 and N_OUT = 3, which gives a ten-cell chain. With this size an input cell sits at the `scan_out` end and an enable cell sits at the `scan_in` end, so a misplaced or swapped position shows up in the serial stream. Three output pads allow patterns where value and enable bits differ from pad to pad and from their neighbours. With these patterns the bench can tell the capture, shift and update paths apart, and can check isolation, capture-over-shift priority and a reset in mid-pattern.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  function automatic int chain_len(input int n_in, input int n_out);
    return n_in + 2 * n_out;
  endfunction

  function automatic int data_pos(input int n_in, input int pad);
    return n_in + 2 * pad;
  endfunction

  function automatic int en_pos(input int n_in, input int pad);
    return n_in + 2 * pad + 1;
  endfunction
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic cap_d,
  input  logic ser_d,
  output logic q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       q <= 1'b0;
    else if (cap_en)   q <= cap_d;
    else if (shift_en) q <= ser_d;
  end
endmodule

// File: rtl/bscan_upd.sv
module bscan_upd (
  input  logic tck,
  input  logic trst_n,
  input  logic upd_en,
  input  logic d,
  output logic q
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     q <= 1'b0;
    else if (upd_en) q <= d;
  end
endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux (
  input  logic ext_mode,
  input  logic core_d,
  input  logic core_en,
  input  logic lat_d,
  input  logic lat_en,
  output logic pin_d,
  output logic pin_en
);
  always_comb begin
    if (ext_mode) begin
      pin_d  = lat_d;
      pin_en = lat_en;
    end else begin
      pin_d  = core_d;
      pin_en = core_en;
    end
  end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             cap_en,
  input  logic             shift_en,
  input  logic             upd_en,
  input  logic             ext_mode,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  import bscan_pkg::*;

  localparam int LEN = chain_len(N_IN, N_OUT);

  logic [LEN-1:0]   cap_vec;
  logic [LEN-1:0]   chain_q;
  logic [LEN-1:0]   ser_vec;
  logic [N_OUT-1:0] dat_lat;
  logic [N_OUT-1:0] en_lat;

  assign ser_vec  = {scan_in, chain_q[LEN-1:1]};
  assign scan_out = chain_q[0];
  assign core_in  = pin_in;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign cap_vec[i] = pin_in[i];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    localparam int DP = data_pos(N_IN, j);
    localparam int EP = en_pos(N_IN, j);

    assign cap_vec[DP] = pin_out[j];
    assign cap_vec[EP] = pin_oe[j];

    bscan_upd u_dat (
      .tck(tck), .trst_n(trst_n), .upd_en(upd_en),
      .d(chain_q[DP]), .q(dat_lat[j])
    );
    bscan_upd u_en (
      .tck(tck), .trst_n(trst_n), .upd_en(upd_en),
      .d(chain_q[EP]), .q(en_lat[j])
    );
    bscan_pin_mux u_mux (
      .ext_mode(ext_mode), .core_d(core_out[j]), .core_en(core_oe[j]),
      .lat_d(dat_lat[j]), .lat_en(en_lat[j]),
      .pin_d(pin_out[j]), .pin_en(pin_oe[j])
    );
  end

  for (genvar k = 0; k < LEN; k++) begin : g_cell
    bscan_cell u_cell (
      .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shift_en(shift_en),
      .cap_d(cap_vec[k]), .ser_d(ser_vec[k]), .q(chain_q[k])
    );
  end
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int LEN   = N_IN + 2 * N_OUT
) (
  input logic             tck,
  input logic             trst_n,
  input logic             cap_en,
  input logic             shift_en,
  input logic             upd_en,
  input logic             ext_mode,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_OUT-1:0] pin_out,
  input logic [N_OUT-1:0] pin_oe,
  input logic             scan_out,
  input logic [LEN-1:0]   chain_q,
  input logic [N_OUT-1:0] en_lat
);
  // R1: reset clears the serial output and releases pads in external mode
  p_reset_clear_r1: assert property (@(posedge tck)
    !trst_n |-> (scan_out == 1'b0) && ((pin_oe & {N_OUT{ext_mode}}) == '0));

  // R4 and R9: capture loads input cells even when shift is also requested
  p_capture_r4: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> chain_q[N_IN-1:0] == $past(pin_in));

  // R5: one shift moves every cell one position toward scan_out
  p_shift_r5: assert property (@(posedge tck) disable iff (!trst_n)
    shift_en && !cap_en |=> (chain_q[LEN-2:0] == $past(chain_q[LEN-1:1]))
                             && (scan_out == $past(chain_q[1])));

  // R6: without an update strobe the pads hold in external mode
  p_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
    ext_mode && $past(ext_mode) && !upd_en |-> $stable(pin_out) && $stable(pin_oe));

  // R8: no pad is enabled beyond what the enable latches allow
  p_iso_r8: assert property (@(posedge tck) disable iff (!trst_n)
    ext_mode |-> $countones(pin_oe & ~en_lat) == 0);
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shift_en(shift_en),
  .upd_en(upd_en), .ext_mode(ext_mode), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .scan_out(scan_out), .chain_q(chain_q), .en_lat(en_lat)
);

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 4;
  localparam int N_OUT = 3;
  localparam int LEN   = N_IN + 2 * N_OUT;

  logic tck = 1'b0;
  logic trst_n = 1'b1;
  logic cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, ext_mode = 1'b1;
  logic scan_in = 1'b0;
  logic scan_out;
  logic [N_OUT-1:0] core_out = '0, core_oe = '0;
  logic [N_IN-1:0]  core_in;
  logic [N_IN-1:0]  pin_in = '0;
  logic [N_OUT-1:0] pin_out, pin_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic  exp_q[$];
  string tag_q[$];
  logic  obs_q[$];

  always #(CLK_PERIOD/2) tck = ~tck;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) i_bscan_chain (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shift_en(shift_en),
    .upd_en(upd_en), .ext_mode(ext_mode), .scan_in(scan_in),
    .scan_out(scan_out), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R3 layout computed by the bench
  function automatic logic [LEN-1:0] build(input logic [N_IN-1:0] ins,
                                           input logic [N_OUT-1:0] d,
                                           input logic [N_OUT-1:0] e);
    logic [LEN-1:0] v;
    for (int i = 0; i < N_IN; i++) v[i] = ins[i];
    for (int j = 0; j < N_OUT; j++) begin
      v[N_IN + 2*j]     = d[j];
      v[N_IN + 2*j + 1] = e[j];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pops expected serial bits and compares with observed ones
  always @(negedge tck) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic  g, e;
      string t;
      g = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {31'b0, g}, {31'b0, e});
    end
  end

  // driver: shifts v in, expecting old contents exp_old out when checking
  task automatic shift_vec(input logic [LEN-1:0] v, input bit check,
                           input logic [LEN-1:0] exp_old, input string tag);
    for (int k = 0; k < LEN; k++) begin
      if (check) begin
        exp_q.push_back(exp_old[k]);
        tag_q.push_back(tag);
        obs_q.push_back(scan_out);
      end
      scan_in  = v[k];
      shift_en = 1'b1;
      @(posedge tck); #1;
    end
    shift_en = 1'b0;
  endtask

  task automatic capture();
    cap_en = 1'b1;
    @(posedge tck); #1;
    cap_en = 1'b0;
  endtask

  task automatic update();
    upd_en = 1'b1;
    @(negedge tck);
    @(posedge tck); #1;
    upd_en = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(posedge tck);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R5: %0d serial bits not observed, expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] v1, v2, v3, v4, v5;
    #2 trst_n = 1'b0;
    @(posedge tck); #1;
    // R1 reset state
    chk("R1 scan_out", {31'b0, scan_out}, 0);
    chk("R1 pin_oe", {29'b0, pin_oe}, 0);
    chk("R1 pin_out", {29'b0, pin_out}, 0);
    @(posedge tck); #1;
    trst_n = 1'b1;

    // R2 normal mode passes core values
    ext_mode = 1'b0; core_out = 3'b011; core_oe = 3'b101; pin_in = 4'b1010;
    #1;
    chk("R2 pin_out", {29'b0, pin_out}, 3'b011);
    chk("R2 pin_oe", {29'b0, pin_oe}, 3'b101);
    chk("R2 core_in", {28'b0, core_in}, 4'b1010);

    // R4 R3 capture in normal mode then shift out
    capture();
    v1 = build(4'b0110, 3'b101, 3'b011);
    shift_vec(v1, 1, build(4'b1010, 3'b011, 3'b101), "R4 capture normal");

    // R5 shifted bits come back unchanged
    v2 = build(4'b1100, 3'b110, 3'b111);
    shift_vec(v2, 1, v1, "R5 shift through");
    update();
    chk("R2 pins ignore update", {26'b0, pin_out, pin_oe}, {3'b011, 3'b101});

    // R7 external mode drives latches
    ext_mode = 1'b1; #1;
    chk("R7 pin_out", {29'b0, pin_out}, 3'b110);
    chk("R7 pin_oe", {29'b0, pin_oe}, 3'b111);

    // R6 shifting leaves pads alone until update
    v3 = build(4'b0000, 3'b001, 3'b010);
    shift_vec(v3, 1, v2, "R5 second pass");
    chk("R6 hold pin_out", {29'b0, pin_out}, 3'b110);
    chk("R6 hold pin_oe", {29'b0, pin_oe}, 3'b111);
    update();
    chk("R6 R3 new pin_out", {29'b0, pin_out}, 3'b001);
    chk("R6 R3 new pin_oe", {29'b0, pin_oe}, 3'b010);

    // R8 isolation
    core_oe = 3'b111;
    v4 = build(4'b0000, 3'b111, 3'b000);
    shift_vec(v4, 1, v3, "R5 third pass");
    update();
    chk("R8 isolated pin_oe", {29'b0, pin_oe}, 3'b000);

    // R9 capture wins over shift; R4 in external mode
    pin_in = 4'b0101; scan_in = 1'b1;
    cap_en = 1'b1; shift_en = 1'b1;
    @(posedge tck); #1;
    cap_en = 1'b0; shift_en = 1'b0;
    chk("R2 core_in ext", {28'b0, core_in}, 4'b0101);
    v5 = build(4'b1111, 3'b111, 3'b111);
    shift_vec(v5, 1, build(4'b0101, 3'b111, 3'b000), "R9 capture priority");

    // R1 reset in mid-pattern
    update();
    chk("R7 all driven", {29'b0, pin_oe}, 3'b111);
    trst_n = 1'b0; #1;
    chk("R1 mid reset scan_out", {31'b0, scan_out}, 0);
    chk("R1 mid reset pin_oe", {29'b0, pin_oe}, 0);
    @(posedge tck); #1;
    trst_n = 1'b1;
    shift_vec('0, 1, '0, "R1 cleared chain");
    finish_run();
  end
endmodule